// File: doc/BRIEF.md
# Driver Strength Tracking Calibrator

This block holds the 6-bit strength code for a bank of output drivers. It steers that code toward the value an analog comparator asks for, and that comparator senses an external reference resistor. Every eighth clock the block samples the comparator's two flags and moves an internal working code by one step at most: up, down, or not at all. The working code saturates at the ends of its 64-step range and never wraps.

The drivers must not change strength while they drive the line. The working code is therefore copied to the applied output code only in cycles when the outputs are high-impedance. Write and deselect cycles open such windows. While the outputs stay driven the working code keeps tracking, and the next high-impedance cycle applies only its latest value. After reset a settle counter runs for a fixed number of cycles. The calibrated flag then rises on the first low-Z to high-Z transition that follows, and it stays set until the next reset.

Top module: `drv_strength_tracker`

## Requirements
- R1: While `rst_n` is low at a rising edge, the working code and `drv_code` become 32 (mid-scale), `cal_done` becomes 0, and the cadence and settle counters clear.
- R2: Evaluations happen only on the 8th, 16th, 24th, ... rising edge counted from the first edge with `rst_n` high. The working code can change on no other edge.
- R3: At an evaluation edge, `cmp_up`=1 with `cmp_dn`=0 raises the working code by exactly 1, and `cmp_dn`=1 with `cmp_up`=0 lowers it by exactly 1.
- R4: At an evaluation edge with both comparator flags at 1, or both at 0, the working code holds.
- R5: The working code stays at 63 when asked to go up and at 0 when asked to go down. It never wraps.
- R6: `drv_code` changes only on a rising edge where `out_hiz`=1. On that edge it takes the working code as it stood before that edge, so an evaluation result appears on `drv_code` one edge later.
- R7: While `out_hiz`=0 the working code keeps tracking. The first high-impedance edge applies the latest working code, with no intermediate values.
- R8: A settle counter counts edges with `rst_n` high up to 520. `cal_done` sets on an edge where `out_hiz`=1, `out_hiz` was 0 at the previous edge, and at least 520 edges have already elapsed. A transition on edge 520 or earlier does not count. A high-Z level held from reset is not a transition.
- R9: Once set, `cal_done` stays 1 whatever `out_hiz` and the comparator do, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmp_up | input | 1 | Comparator: target strength is above the working code |
| cmp_dn | input | 1 | Comparator: target strength is below the working code |
| out_hiz | input | 1 | Drivers are high-impedance in this cycle |
| drv_code | output | 6 | Strength code applied to the drivers |
| cal_done | output | 1 | Calibrated flag, sticky until reset |

## Verification
On every cycle the assertions check that the working code moves by at most one step and only on a cadence tick, and that it holds at either end of the range. They also check that `drv_code` stays frozen across driven cycles, that `cal_done` rises only at a low-Z to high-Z edge, and that it never falls. The exact 8-cycle phase, the one-edge lag between evaluation and application, and the settle boundary at edge 520 against edge 521 can only be shown by the directed scenarios. The same holds for the collapse of several evaluations into a single applied value after a long driven stretch.

// File: rtl/drv_cal_pkg.sv
// Package: shared widths, constants and the step-direction type for the
// driver strength calibrator. Assumes a code of at most 16 bits.
package drv_cal_pkg;

    localparam int CODE_W = 6;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_dir_e;

    // Map the two comparator flags to a step direction; conflicting or absent flags hold.
    function automatic step_dir_e decode_dir(input logic up, input logic dn);
        if (up && !dn) begin
            return STEP_UP;
        end else if (dn && !up) begin
            return STEP_DOWN;
        end
        return STEP_HOLD;
    endfunction

endpackage

// File: rtl/cal_cadence_timer.sv
// Cadence timer: pulses eval_tick for one cycle on every PERIOD-th clock
// after reset release. Assumes PERIOD >= 2.
module cal_cadence_timer #(
    parameter int PERIOD = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic eval_tick
);
    localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] phase_q;

    // Free-running phase counter that wraps after PERIOD cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign eval_tick = (phase_q == LAST);

endmodule

// File: rtl/cal_step_tracker.sv
// Step tracker: holds the working strength code and moves it by one step
// on each evaluation tick toward the comparator's request, saturating at
// both ends. Assumes the comparator flags are already synchronous.
module cal_step_tracker
    import drv_cal_pkg::*;
#(
    parameter int W = CODE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         eval_tick,
    input  logic         cmp_up,
    input  logic         cmp_dn,
    output logic [W-1:0] work_code
);
    localparam logic [W-1:0] MID_CODE = W'(1 << (W - 1));
    localparam logic [W-1:0] MAX_CODE = {W{1'b1}};

    step_dir_e    dir;
    logic [W-1:0] next_code;

    // Work out the next code from the requested direction with end-stop saturation.
    always_comb begin
        dir       = decode_dir(cmp_up, cmp_dn);
        next_code = work_code;
        case (dir)
            STEP_UP:   if (work_code != MAX_CODE) next_code = work_code + 1'b1;
            STEP_DOWN: if (work_code != '0)       next_code = work_code - 1'b1;
            default:   next_code = work_code;
        endcase
    end

    // Register the working code, advancing only on an evaluation tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_code <= MID_CODE;
        end else if (eval_tick) begin
            work_code <= next_code;
        end
    end

endmodule

// File: rtl/cal_apply_gate.sv
// Apply gate: copies the working code to the drivers only in high-impedance
// cycles, runs the power-up settle counter, and raises the sticky calibrated
// flag on the first low-Z to high-Z edge after settling. Assumes out_hiz is
// synchronous to clk.
module cal_apply_gate #(
    parameter int W             = 6,
    parameter int SETTLE_CYCLES = 520
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         out_hiz,
    input  logic [W-1:0] work_code,
    output logic [W-1:0] drv_code,
    output logic         cal_done
);
    localparam int              SET_W    = $clog2(SETTLE_CYCLES + 1);
    localparam logic [SET_W-1:0] SET_END = SET_W'(SETTLE_CYCLES);
    localparam logic [W-1:0]     MID_CODE = W'(1 << (W - 1));

    logic [SET_W-1:0] settle_q;
    logic             settled;
    logic             hiz_q;
    logic             hiz_rise;

    assign settled  = (settle_q == SET_END);
    assign hiz_rise = out_hiz && !hiz_q;

    // Count elapsed cycles since reset, stopping at the settle limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            settle_q <= '0;
        end else if (!settled) begin
            settle_q <= settle_q + 1'b1;
        end
    end

    // Remember the previous high-Z state; reset as high-Z so a held level is no edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hiz_q <= 1'b1;
        end else begin
            hiz_q <= out_hiz;
        end
    end

    // Pass the working code to the drivers only while they are not driving.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_code <= MID_CODE;
        end else if (out_hiz) begin
            drv_code <= work_code;
        end
    end

    // Set the calibrated flag on the first post-settle high-Z entry; hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_done <= 1'b0;
        end else if (settled && hiz_rise) begin
            cal_done <= 1'b1;
        end
    end

endmodule

// File: rtl/drv_strength_tracker.sv
// Top level of the driver strength calibrator: cadence timer, step tracker
// and apply gate in series. Assumes all inputs are synchronous to clk and
// that the comparator result is valid whenever it is sampled.
module drv_strength_tracker
    import drv_cal_pkg::*;
#(
    parameter int EVAL_PERIOD   = 8,
    parameter int SETTLE_CYCLES = 520
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_up,
    input  logic              cmp_dn,
    input  logic              out_hiz,
    output logic [CODE_W-1:0] drv_code,
    output logic              cal_done
);
    logic              eval_tick;
    logic [CODE_W-1:0] work_code;

    cal_cadence_timer #(
        .PERIOD (EVAL_PERIOD)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .eval_tick (eval_tick)
    );

    cal_step_tracker #(
        .W (CODE_W)
    ) u_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .eval_tick (eval_tick),
        .cmp_up    (cmp_up),
        .cmp_dn    (cmp_dn),
        .work_code (work_code)
    );

    cal_apply_gate #(
        .W             (CODE_W),
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_apply (
        .clk       (clk),
        .rst_n     (rst_n),
        .out_hiz   (out_hiz),
        .work_code (work_code),
        .drv_code  (drv_code),
        .cal_done  (cal_done)
    );

endmodule

// File: rtl/drv_strength_tracker_chk.sv
// Checker for the driver strength calibrator, bound to the top module.
// Observes ports plus the internal tick and working code.
module drv_strength_tracker_chk #(
    parameter int W = 6
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cmp_up,
    input logic         cmp_dn,
    input logic         out_hiz,
    input logic         eval_tick,
    input logic [W-1:0] work_code,
    input logic [W-1:0] drv_code,
    input logic         cal_done
);
    localparam logic [W-1:0] MAX_CODE = {W{1'b1}};

    // R3: the working code moves by at most one step between cycles.
    p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, work_code} == {1'b0, $past(work_code)}) ||
        ({1'b0, work_code} == {1'b0, $past(work_code)} + 1'b1) ||
        ({1'b0, work_code} + 1'b1 == {1'b0, $past(work_code)}));

    // R2: the working code holds outside evaluation ticks.
    p_tick_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_tick |=> $stable(work_code));

    // R5: no wrap at the top.
    p_sat_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (work_code == MAX_CODE && cmp_up && !cmp_dn) |=> work_code == MAX_CODE);

    // R5: no wrap at the bottom.
    p_sat_bottom_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (work_code == '0 && cmp_dn && !cmp_up) |=> work_code == '0);

    // R6: the applied code is frozen while the outputs drive.
    p_frozen_lowz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_hiz |=> $stable(drv_code));

    // R8: the flag only rises at a low-Z to high-Z edge.
    p_rise_on_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_done) |-> ($past(out_hiz) && !$past(out_hiz, 2)));

    // R9: the flag never falls outside reset.
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |=> cal_done);

endmodule

bind drv_strength_tracker drv_strength_tracker_chk #(
    .W (drv_cal_pkg::CODE_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_up    (cmp_up),
    .cmp_dn    (cmp_dn),
    .out_hiz   (out_hiz),
    .eval_tick (eval_tick),
    .work_code (work_code),
    .drv_code  (drv_code),
    .cal_done  (cal_done)
);

// File: tb/test_drv_strength_tracker.sv
// Directed bench for the driver strength calibrator: one task per scenario,
// inputs driven and outputs sampled on the falling edge.
module test_drv_strength_tracker;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_up = 1'b0;
    logic       cmp_dn = 1'b0;
    logic       out_hiz = 1'b1;
    logic [5:0] drv_code;
    logic       cal_done;

    int checks = 0;
    int errors = 0;

    drv_strength_tracker i_drv_strength_tracker (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_up   (cmp_up),
        .cmp_dn   (cmp_dn),
        .out_hiz  (out_hiz),
        .drv_code (drv_code),
        .cal_done (cal_done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Compare one value and report a mismatch.
    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance n rising edges, ending on a falling edge.
    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Reset with the given high-Z level; returns with zero edges elapsed.
    task automatic do_reset(input logic hiz);
        @(negedge clk);
        rst_n = 1'b0; cmp_up = 1'b0; cmp_dn = 1'b0; out_hiz = hiz;
        step(3);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset(1'b1);
        check("R1 code", drv_code, 32);
        check("R1 cal", cal_done, 0);
    endtask

    task automatic t_cadence_up();
        do_reset(1'b1);
        cmp_up = 1'b1;
        step(8);
        check("R2 no change before first tick", drv_code, 32);
        step(1);
        check("R3 up step applied", drv_code, 33);
        step(7);
        check("R2 held between ticks", drv_code, 33);
        step(1);
        check("R6 second step", drv_code, 34);
    endtask

    task automatic t_down();
        do_reset(1'b1);
        cmp_dn = 1'b1;
        step(25);
        check("R3 three down steps", drv_code, 29);
    endtask

    task automatic t_hold();
        do_reset(1'b1);
        cmp_up = 1'b1; cmp_dn = 1'b1;
        step(64);
        check("R4 both flags hold", drv_code, 32);
        cmp_up = 1'b0; cmp_dn = 1'b0;
        step(64);
        check("R4 no flags hold", drv_code, 32);
    endtask

    task automatic t_saturate();
        do_reset(1'b1);
        cmp_up = 1'b1;
        step(8 * 40 + 1);
        check("R5 top saturation", drv_code, 63);
        do_reset(1'b1);
        cmp_dn = 1'b1;
        step(8 * 40 + 1);
        check("R5 bottom saturation", drv_code, 0);
    endtask

    task automatic t_lowz_tracking();
        do_reset(1'b0);
        cmp_up = 1'b1;
        step(40);
        check("R6 frozen while driving", drv_code, 32);
        cmp_up = 1'b0; out_hiz = 1'b1;
        step(1);
        check("R7 latest value applied", drv_code, 37);
    endtask

    task automatic t_cal_flag();
        do_reset(1'b1);
        step(600);
        check("R8 held high-Z is no edge", cal_done, 0);
        out_hiz = 1'b0; step(1); out_hiz = 1'b1; step(1);
        check("R8 set on post-settle edge", cal_done, 1);
        out_hiz = 1'b0; cmp_dn = 1'b1; step(30);
        check("R9 sticky", cal_done, 1);
        do_reset(1'b1);
        check("R9 cleared by reset", cal_done, 0);
    endtask

    task automatic t_cal_boundary();
        do_reset(1'b0);
        step(100); out_hiz = 1'b1; step(1); out_hiz = 1'b0; step(1);
        check("R8 early edge ignored", cal_done, 0);
        do_reset(1'b0);
        step(519); out_hiz = 1'b1; step(1);
        check("R8 edge at 520 ignored", cal_done, 0);
        step(50);
        check("R8 no later edge", cal_done, 0);
        do_reset(1'b0);
        step(520); out_hiz = 1'b1; step(1);
        check("R8 edge at 521 sets", cal_done, 1);
    endtask

    initial begin
        t_reset_state();
        t_cadence_up();
        t_down();
        t_hold();
        t_saturate();
        t_lowz_tracking();
        t_cal_flag();
        t_cal_boundary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule